// File: doc/BRIEF.md
# Selectable-Semantics Double-to-Integer Converter

This block converts a 64-bit IEEE binary64 operand into a signed or unsigned integer of 8, 16, 32 or 64 bits. It always rounds toward zero. A mode input picks how NaN, infinities and values outside the target range are resolved. The choices are: saturation with NaN going to the most negative target value; saturation with NaN going to zero; a 32-bit saturating conversion followed by keeping only the low bits for narrow targets; and wrapping modulo 2^width. The result is always returned as a full 64-bit word, sign-extended for signed targets and zero-extended for unsigned ones.

An overflow flag reports a NaN input or a truncated value that does not fit the target type. The flag never traps, and the mode's defined result is still delivered. Mode codes that are not defined raise an illegal flag instead of producing a value. The block keeps no state other than its output register, and that register changes only on an accepted conversion.

The converter is a single pipeline stage. Unpacking and alignment, range checking and mode selection are all combinational, and the outputs are registered on the clock edge that accepts `valid_i`.

Top module: `fpcvt_top`

## Requirements
- R1: A conversion presented with `valid_i` high is captured at a rising clock edge, and its results appear on the outputs with `valid_o` high after that same edge. `valid_o` is low after any edge at which `valid_i` was low, and low during reset.
- R2: Every legal mode truncates toward zero. A magnitude below 1.0, including -0.0, yields 0 with `ovf_o` low. Example: -3.99 to signed 32-bit gives -3.
- R3: In legal modes `ovf_o` is high exactly when the input is NaN or infinite, or when the truncated value lies outside the target range. The target range is [-2^(W-1), 2^(W-1)-1] for signed targets and [0, 2^W-1] for unsigned ones. The mode's result is still delivered when the flag is set.
- R4: Mode 0 saturates out-of-range values and infinities to the nearer target limit. A NaN input gives the target minimum: -2^(W-1) for signed targets, 0 for unsigned ones.
- R5: Mode 1 saturates out-of-range values and infinities at every width, and a NaN input gives 0. Example: 257.0 to unsigned 8-bit gives 255.
- R6: In mode 2, 8-bit and 16-bit targets first take the mode-1 conversion at 32 bits with the same signedness, then keep its low W bits and extend them. 32-bit and 64-bit targets behave as in mode 1. Example: 257.0 to unsigned 8-bit gives 1.
- R7: Mode 3 returns the truncated integer modulo 2^W, extended to 64 bits, and this holds for magnitudes of 2^64 and above. NaN and infinities give 0.
- R8: `wsel_i` selects the target width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. `signed_i` high selects a signed target. Bits above W are copies of bit W-1 for signed targets and zero for unsigned ones.
- R9: Mode codes 4 to 31 set `illegal_o` and give `result_o` = 0 with `ovf_o` low. Legal modes clear `illegal_o`.
- R10: While `valid_i` is low, `result_o`, `ovf_o` and `illegal_o` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Conversion request strobe |
| op_i | input | 64 | Binary64 operand |
| mode_i | input | 5 | Semantics select (0 to 3 legal) |
| signed_i | input | 1 | Signed target when high |
| wsel_i | input | 2 | Target width select |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 64 | Converted, extended integer |
| ovf_o | output | 1 | Input is NaN, infinite or out of target range |
| illegal_o | output | 1 | Undefined mode code |

## Verification
Every result, `valid_o`, `ovf_o` and `illegal_o` included, is due exactly one rising edge after the request. `valid_o` drops one edge after `valid_i` drops. The bench applies inputs on the falling edge and reads outputs on the next falling edge, half a period after the capturing edge. It advances its behavioural model at that same point, so each comparison lines up with the cycle in which the register has settled. The hold behaviour is checked the same way, on the falling edge after an idle cycle with changed inputs.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  localparam int FP_EXP_W  = 11;
  localparam int FP_FRAC_W = 52;
  localparam int FP_INT_W  = 64;
  localparam int MODE_W    = 5;

  localparam logic [MODE_W-1:0] MODE_NATIVE = 5'd0;
  localparam logic [MODE_W-1:0] MODE_SAT    = 5'd1;
  localparam logic [MODE_W-1:0] MODE_T32    = 5'd2;
  localparam logic [MODE_W-1:0] MODE_WRAP   = 5'd3;

  localparam logic [1:0] WSEL_8  = 2'd0;
  localparam logic [1:0] WSEL_16 = 2'd1;
  localparam logic [1:0] WSEL_32 = 2'd2;
  localparam logic [1:0] WSEL_64 = 2'd3;

  // truncated magnitude plus classification of the operand
  typedef struct packed {
    logic                sign;
    logic                nan;
    logic                inf;
    logic                huge;  // |x| >= 2^FP_INT_W
    logic [FP_INT_W-1:0] mag;   // low FP_INT_W bits of trunc(|x|)
  } fp_int_t;

  function automatic logic [FP_INT_W-1:0] fit_width(input logic [FP_INT_W-1:0] v,
                                                    input logic [1:0] wsel,
                                                    input logic sgn);
    logic [FP_INT_W-1:0] res;
    int tw;
    logic fill;
    tw   = 8 << wsel;
    fill = sgn & v[tw-1];
    for (int i = 0; i < FP_INT_W; i++) res[i] = (i < tw) ? v[i] : fill;
    return res;
  endfunction

endpackage

// File: rtl/fpcvt_unpack.sv
module fpcvt_unpack
  import fpcvt_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output fp_int_t               val_o
);
  localparam int INT_W = FP_INT_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int E_W   = EXP_W + 1;
  localparam logic [E_W-1:0] E_ONE  = E_W'(BIAS);
  localparam logic [E_W-1:0] E_LEFT = E_W'(BIAS + FRAC_W);
  localparam logic [E_W-1:0] E_HUGE = E_W'(BIAS + INT_W);

  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic [E_W-1:0]    e_x, lsh, rsh;
  logic              special;
  logic [INT_W-1:0]  sig, shl, shr;

  assign sign    = op_i[EXP_W+FRAC_W];
  assign expo    = op_i[EXP_W+FRAC_W-1 -: EXP_W];
  assign frac    = op_i[FRAC_W-1:0];
  assign e_x     = {1'b0, expo};
  assign special = &expo;
  assign sig     = {{(INT_W-SIG_W){1'b0}}, 1'b1, frac};

  // integer part: shift left above the fraction width, right below it
  assign lsh = e_x - E_LEFT;
  assign rsh = E_LEFT - e_x;
  assign shl = sig << lsh;
  assign shr = sig >> rsh;

  always_comb begin
    val_o.sign = sign;
    val_o.nan  = special & (|frac);
    val_o.inf  = special & ~(|frac);
    val_o.huge = ~special & (e_x >= E_HUGE);
    if (special || e_x < E_ONE) val_o.mag = '0;
    else if (e_x >= E_LEFT)     val_o.mag = shl;
    else                        val_o.mag = shr;
  end

endmodule

// File: rtl/fpcvt_limits.sv
module fpcvt_limits
  import fpcvt_pkg::*;
(
  input  fp_int_t             val_i,
  input  logic [1:0]          wsel_i,
  input  logic                sgn_i,
  output logic                fits_o,
  output logic [FP_INT_W-1:0] max_o,
  output logic [FP_INT_W-1:0] min_o
);
  localparam int INT_W  = FP_INT_W;
  localparam int N_WSEL = 4;

  logic [INT_W-1:0] pos_lim [N_WSEL];
  logic [INT_W-1:0] neg_lim [N_WSEL];
  logic [INT_W-1:0] pos, neg;

  for (genvar g = 0; g < N_WSEL; g++) begin : g_width
    localparam int W = 8 << g;
    localparam logic [INT_W-1:0] ONE  = INT_W'(1);
    localparam logic [INT_W-1:0] FULL = (W >= INT_W) ? {INT_W{1'b1}} : ((ONE << W) - ONE);
    localparam logic [INT_W-1:0] HALF = ONE << (W - 1);
    assign pos_lim[g] = sgn_i ? (HALF - ONE) : FULL;
    assign neg_lim[g] = sgn_i ? HALF : '0;
  end

  assign pos = pos_lim[wsel_i];
  assign neg = neg_lim[wsel_i];

  // magnitude bounds: negative side allows one more step for signed targets
  assign fits_o = ~val_i.nan & ~val_i.inf & ~val_i.huge &
                  (val_i.sign ? (val_i.mag <= neg) : (val_i.mag <= pos));
  assign max_o  = pos;
  assign min_o  = '0 - neg;

endmodule

// File: rtl/fpcvt_select.sv
module fpcvt_select
  import fpcvt_pkg::*;
(
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                sgn_i,
  input  logic [1:0]          wsel_i,
  input  logic                sign_i,
  input  logic                nan_i,
  input  logic                inf_i,
  input  logic [FP_INT_W-1:0] mag_i,
  input  logic                fits_i,
  input  logic [FP_INT_W-1:0] max_i,
  input  logic [FP_INT_W-1:0] min_i,
  input  logic                fits32_i,
  input  logic [FP_INT_W-1:0] max32_i,
  input  logic [FP_INT_W-1:0] min32_i,
  output logic [FP_INT_W-1:0] res_o,
  output logic                ovf_o,
  output logic                illegal_o
);
  localparam int INT_W = FP_INT_W;

  logic             legal;
  logic [INT_W-1:0] exact, sat_t, sat32, wrap;

  always_comb begin
    legal = (mode_i <= MODE_WRAP);
    exact = sign_i ? ('0 - mag_i) : mag_i;
    sat_t = fits_i ? exact : (sign_i ? min_i : max_i);
    sat32 = nan_i ? '0 : (fits32_i ? exact : (sign_i ? min32_i : max32_i));
    wrap  = (nan_i | inf_i) ? '0 : fit_width(exact, wsel_i, sgn_i);
    unique case (mode_i)
      MODE_NATIVE: res_o = nan_i ? min_i : sat_t;
      MODE_SAT:    res_o = nan_i ? '0 : sat_t;
      MODE_T32:    res_o = (wsel_i < WSEL_32) ? fit_width(sat32, wsel_i, sgn_i)
                                              : (nan_i ? '0 : sat_t);
      MODE_WRAP:   res_o = wrap;
      default:     res_o = '0;
    endcase
    ovf_o     = legal & ~fits_i;
    illegal_o = ~legal;
  end

endmodule

// File: rtl/fpcvt_top.sv
module fpcvt_top
  import fpcvt_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [EXP_W+FRAC_W:0]       op_i,
  input  logic [MODE_W-1:0]           mode_i,
  input  logic                        signed_i,
  input  logic [1:0]                  wsel_i,
  output logic                        valid_o,
  output logic [FP_INT_W-1:0]         result_o,
  output logic                        ovf_o,
  output logic                        illegal_o
);
  localparam int INT_W = FP_INT_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] E_ONE = EXP_W'(BIAS);

  fp_int_t          val;
  logic             fits, fits32, ovf_d, ill_d;
  logic [INT_W-1:0] max_v, min_v, max32, min32, res_d;

  fpcvt_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .op_i  (op_i),
    .val_o (val)
  );

  fpcvt_limits u_lim_tgt (
    .val_i  (val),
    .wsel_i (wsel_i),
    .sgn_i  (signed_i),
    .fits_o (fits),
    .max_o  (max_v),
    .min_o  (min_v)
  );

  fpcvt_limits u_lim_32 (
    .val_i  (val),
    .wsel_i (WSEL_32),
    .sgn_i  (signed_i),
    .fits_o (fits32),
    .max_o  (max32),
    .min_o  (min32)
  );

  fpcvt_select u_select (
    .mode_i    (mode_i),
    .sgn_i     (signed_i),
    .wsel_i    (wsel_i),
    .sign_i    (val.sign),
    .nan_i     (val.nan),
    .inf_i     (val.inf),
    .mag_i     (val.mag),
    .fits_i    (fits),
    .max_i     (max_v),
    .min_i     (min_v),
    .fits32_i  (fits32),
    .max32_i   (max32),
    .min32_i   (min32),
    .res_o     (res_d),
    .ovf_o     (ovf_d),
    .illegal_o (ill_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      ovf_o     <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        ovf_o     <= ovf_d;
        illegal_o <= ill_d;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_SUB_ONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i <= MODE_WRAP && op_i[EXP_W+FRAC_W-1 -: EXP_W] < E_ONE
    |=> result_o == '0 && !ovf_o); // R2
  AST_NAN_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i <= MODE_WRAP && (&op_i[EXP_W+FRAC_W-1 -: EXP_W])
    |=> ovf_o); // R3
  AST_UNSIGNED_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i <= MODE_WRAP && !signed_i && wsel_i != WSEL_64
    |=> result_o[INT_W-1:INT_W/2] == '0); // R8
  AST_ILLEGAL_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i > MODE_WRAP |=> illegal_o && !ovf_o && result_o == '0); // R9
  AST_LEGAL_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i <= MODE_WRAP |=> !illegal_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(ovf_o) && $stable(illegal_o)); // R10

endmodule

// File: tb/tb_fpcvt_top.sv
module tb_fpcvt_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_i = '0;
  logic [4:0]  mode_i = '0;
  logic        signed_i = 1'b0;
  logic [1:0]  wsel_i = '0;
  logic        valid_o, ovf_o, illegal_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpcvt_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .mode_i(mode_i),
    .signed_i(signed_i), .wsel_i(wsel_i), .valid_o(valid_o), .result_o(result_o),
    .ovf_o(ovf_o), .illegal_o(illegal_o)
  );

  function automatic logic [63:0] ext_bits(input logic [63:0] v, input int w, input logic sg);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i < w) ? v[i] : (sg & v[w-1]);
    return r;
  endfunction

  function automatic logic [63:0] clamp(input logic signed [139:0] v,
                                        input logic signed [139:0] lo,
                                        input logic signed [139:0] hi);
    logic signed [139:0] t;
    t = (v < lo) ? lo : ((v > hi) ? hi : v);
    return t[63:0];
  endfunction

  // behavioural reference: wide exact integer arithmetic
  function automatic void ref_conv(input logic [63:0] b, input logic [4:0] md, input logic sg,
                                   input logic [1:0] ws, output logic [63:0] r,
                                   output logic ov, output logic il);
    int e, k, w;
    logic [52:0] m;
    logic s, nan, inf, big, fits;
    logic signed [139:0] v, lo, hi, lo32, hi32;
    logic [63:0] low, t;
    s = b[63]; e = int'(b[62:52]); m = {1'b1, b[51:0]};
    nan = (e == 2047) && (b[51:0] != 0);
    inf = (e == 2047) && (b[51:0] == 0);
    w = 8 << ws;
    v = 0; low = 0; big = 0;
    if (e < 2047 && e >= 1023) begin
      k = e - 1075;
      if (k >= 0) begin
        if (k > 80) big = 1; else v = 140'(m) << k;
        low = (k >= 64) ? 64'd0 : (64'(m) << k);
      end else begin
        v = 140'(m >> (-k));
        low = 64'(m >> (-k));
      end
    end
    if (inf || big) v = 140'sd1 <<< 100;
    if (s) v = -v;
    lo = sg ? -(140'sd1 <<< (w-1)) : 140'sd0;
    hi = sg ? (140'sd1 <<< (w-1)) - 1 : (140'sd1 <<< w) - 1;
    lo32 = sg ? -(140'sd1 <<< 31) : 140'sd0;
    hi32 = sg ? (140'sd1 <<< 31) - 1 : (140'sd1 <<< 32) - 1;
    fits = !nan && !inf && !big && v >= lo && v <= hi;
    il = md > 5'd3;
    ov = !il && !fits;
    case (md)
      5'd0: r = nan ? lo[63:0] : clamp(v, lo, hi);
      5'd1: r = nan ? 64'd0 : clamp(v, lo, hi);
      5'd2: begin
        if (w < 32) begin
          t = nan ? 64'd0 : clamp(v, lo32, hi32);
          r = ext_bits(t, w, sg);
        end else r = nan ? 64'd0 : clamp(v, lo, hi);
      end
      5'd3: r = (nan || inf) ? 64'd0 : ext_bits(s ? (64'd0 - low) : low, w, sg);
      default: r = 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // directed case: expected {valid, illegal, ovf, result}
  task automatic run_one(input logic [63:0] b, input logic [4:0] md, input logic sg,
                         input logic [1:0] ws, input logic [63:0] er, input logic eo,
                         input string tag);
    @(negedge clk);
    valid_i = 1'b1; op_i = b; mode_i = md; signed_i = sg; wsel_i = ws;
    @(negedge clk);
    valid_i = 1'b0;
    check(tag, {valid_o, illegal_o, ovf_o, result_o}, {1'b1, (md > 5'd3), eo, er});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] m_res, prev_res;
    logic m_ovf, m_ill, m_valid, prev_ovf, prev_ill;
    repeat (3) @(negedge clk);
    check("R1 reset", {valid_o, illegal_o, ovf_o, result_o}, 67'd0);
    rst_ni = 1'b1;

    run_one($realtobits(257.0), 5'd1, 1'b0, 2'd0, 64'd255, 1'b1, "R5 257 u8 sat");
    run_one($realtobits(257.0), 5'd2, 1'b0, 2'd0, 64'd1, 1'b1, "R6 257 u8 t32");
    run_one($realtobits(-40000.0), 5'd2, 1'b1, 2'd1, 64'h63C0, 1'b1, "R6 -40000 s16 t32");
    run_one(64'h7FF0000000000000, 5'd2, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R6 +inf s8 t32");
    run_one(64'h7FF8000000000000, 5'd0, 1'b1, 2'd2, 64'hFFFF_FFFF_8000_0000, 1'b1, "R4 NaN s32");
    run_one(64'h7FF8000000000000, 5'd0, 1'b0, 2'd1, 64'd0, 1'b1, "R4 NaN u16");
    run_one(64'h7FF0000000000000, 5'd0, 1'b1, 2'd0, 64'd127, 1'b1, "R4 +inf s8");
    run_one(64'h7FF8000000000001, 5'd1, 1'b1, 2'd3, 64'd0, 1'b1, "R5 NaN s64");
    run_one(64'hFFF0000000000000, 5'd1, 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_8000, 1'b1, "R5 -inf s16");
    run_one($realtobits(-3.99), 5'd0, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, "R2 -3.99 s32");
    run_one(64'h8000000000000000, 5'd3, 1'b0, 2'd3, 64'd0, 1'b0, "R2 -0.0 wrap");
    run_one($realtobits(0.75), 5'd0, 1'b1, 2'd0, 64'd0, 1'b0, "R2 0.75 s8");
    run_one($realtobits(-0.5), 5'd1, 1'b0, 2'd0, 64'd0, 1'b0, "R2 -0.5 u8");
    run_one($realtobits(-128.0), 5'd0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, "R3 -128 s8 fits");
    run_one($realtobits(-129.0), 5'd0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FF80, 1'b1, "R3 -129 s8");
    run_one($realtobits(255.0), 5'd1, 1'b0, 2'd0, 64'd255, 1'b0, "R3 255 u8 fits");
    run_one($realtobits(256.0), 5'd0, 1'b0, 2'd0, 64'd255, 1'b1, "R3 256 u8");
    run_one(64'h43E0000000000000, 5'd0, 1'b1, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, "R4 2^63 s64");
    run_one(64'h43E0000000000000, 5'd1, 1'b0, 2'd3, 64'h8000_0000_0000_0000, 1'b0, "R3 2^63 u64");
    run_one($realtobits(300.0), 5'd3, 1'b0, 2'd0, 64'd44, 1'b1, "R7 300 u8 wrap");
    run_one($realtobits(-1.0), 5'd3, 1'b0, 2'd1, 64'hFFFF, 1'b1, "R7 -1 u16 wrap");
    run_one(64'h43F0000000000001, 5'd3, 1'b0, 2'd3, 64'd4096, 1'b1, "R7 2^64+4096 wrap");
    run_one(64'h7FF8000000000000, 5'd3, 1'b1, 2'd2, 64'd0, 1'b1, "R7 NaN wrap");
    run_one($realtobits(200.0), 5'd3, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFC8, 1'b1, "R8 200 s8 sext");
    run_one($realtobits(200.0), 5'd0, 1'b0, 2'd0, 64'h0000_0000_0000_00C8, 1'b0, "R8 200 u8 zext");
    run_one($realtobits(-70000.5), 5'd1, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFE_EE90, 1'b0, "R8 -70000 s64");
    run_one($realtobits(5.0), 5'd5, 1'b1, 2'd2, 64'd0, 1'b0, "R9 mode 5");
    run_one($realtobits(1.0e30), 5'd31, 1'b0, 2'd3, 64'd0, 1'b0, "R9 mode 31");

    // idle cycle with changed inputs must not disturb the outputs
    run_one($realtobits(-2.0), 5'd0, 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R8 -2 s16");
    @(negedge clk);
    valid_i = 1'b0; op_i = 64'h7FF8000000000000; mode_i = 5'd9; signed_i = 1'b0; wsel_i = 2'd3;
    @(negedge clk);
    check("R10 idle hold", {valid_o, illegal_o, ovf_o, result_o},
          {1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE});

    // random traffic against the model, compared every cycle
    m_res = '0; m_ovf = 0; m_ill = 0; m_valid = 0;
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      if (it > 0)
        check("R1 R3 R10 model", {valid_o, illegal_o, ovf_o, result_o},
              {m_valid, m_ill, m_ovf, m_res});
      valid_i = (it == 0) ? 1'b1 : ($urandom_range(0, 4) != 0);
      op_i = {$urandom, $urandom};
      if ($urandom_range(0, 15) == 0) op_i[62:52] = ($urandom_range(0, 1) != 0) ? 11'h7FF : 11'h000;
      else op_i[62:52] = 11'(1000 + $urandom_range(0, 150));
      if ($urandom_range(0, 31) == 0) op_i[51:0] = '0;
      mode_i = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(4, 31)) : 5'($urandom_range(0, 3));
      signed_i = $urandom_range(0, 1) != 0;
      wsel_i = 2'($urandom_range(0, 3));
      if (valid_i) begin
        ref_conv(op_i, mode_i, signed_i, wsel_i, prev_res, prev_ovf, prev_ill);
        m_res = prev_res; m_ovf = prev_ovf; m_ill = prev_ill;
      end
      m_valid = valid_i;
    end
    @(negedge clk);
    check("R1 R3 R10 model", {valid_o, illegal_o, ovf_o, result_o}, {m_valid, m_ill, m_ovf, m_res});
    valid_i = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule